// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave on a four-wire serial bus that gives an external controller access to a bank of sixteen 8-bit configuration registers. Each access is a fixed 16-bit frame. The frame opens with a command byte that picks read or write and a register number, and closes with a data byte. The bank contents are always visible to the rest of the chip on a flat parallel bus. The block also exposes the register number of the last completed frame.

The serial pins are oversampled by the block's system clock. A synchronizer brings in the serial clock, the active-low select and the data line. A frame state machine then acts on the edges it detects. The states are `ST_IDLE` (deselected), `ST_CMD` (shifting the command byte), `ST_DATA` (shifting the data byte) and `ST_FULL` (sixteen bits held, further clocks ignored).

The transitions are:
- select low moves `ST_IDLE` to `ST_CMD`.
- the 8th serial rising edge moves `ST_CMD` to `ST_DATA`.
- the 16th rising edge moves `ST_DATA` to `ST_FULL`.
- select high moves any selected state back to `ST_IDLE`.

Only the exit from `ST_FULL` commits anything. A write or an address update happens only when a full frame was received.

Top module: `spi_cfg_regs`

## Requirements
- R1: A frame is 16 serial clocks, shifted MSB first. Frame bit 15 (command bit 7) is the direction, 1 = read and 0 = write. Command bits 6..4 are ignored. Command bits 3..0 are the register number. Frame bits 7..0 are the data byte.
- R2: Serial input data is captured on rising edges of the serial clock.
- R3: When select rises after a complete write frame, the addressed register takes the data byte. No other register changes. The new value appears on `regs_flat[8*n +: 8]` within SYNC_STAGES+2 system clocks of the select rise.
- R4: When select rises before the 16th serial clock, no register is written and `cur_addr` keeps its value.
- R5: Serial clocks after the 16th in one frame are ignored, and the committed operation uses the first 16 bits.
- R6: In a read frame, the falling edges of serial clocks 9 to 16 put data bits 7 down to 0 of the named register on `spi_sdo`. A read frame changes no register.
- R7: `spi_sdo_oe` is 0 while select is high and 1 while select is low. `spi_sdo` is high-impedance when the enable is 0.
- R8: After reset, all registers are 00h, `cur_addr` is 0 and `spi_sdo_oe` is 0.
- R9: Every select assertion starts a new frame. Frames may follow one another with a deselect time of 3 system clocks.
- R10: Every complete frame, read or write, loads its register number into `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_csn | input | 1 | Active-low select |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out, high-impedance when not enabled |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo` |
| cur_addr | output | ADDR_W | Register number of the last complete frame |
| regs_flat | output | NUM_REGS*DATA_W | All registers, register n at bits 8n+7..8n |

## Verification
Each pin edge takes SYNC_STAGES+1 system clocks to reach the state machine. After that:
- a committed write shows on `regs_flat` one clock later, SYNC_STAGES+2 in all.
- each read bit and each enable change shows on its port within SYNC_STAGES+2 clocks of the pin edge that caused it.

The bench drives every serial phase for 8 system clocks or more. It samples read bits 7 clocks after each falling edge, just before the next rising edge. It checks the register bank, `cur_addr` and the enable 6 clocks after select rises. Every result is therefore sampled after its latest due cycle and before the next stimulus can disturb it.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int unsigned BYTE_BITS  = 8;
    localparam int unsigned FRAME_BITS = 2 * BYTE_BITS;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_FULL = 2'd3
    } frame_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= pins_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign pins_out = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              sdo_bit,
    output logic              sdo_oe
);

    localparam int unsigned FB    = 2 * DATA_W;
    localparam int unsigned CNT_W = $clog2(FB + 1);
    localparam int unsigned OUT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_CMD_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT     = CNT_W'(FB - 1);
    localparam logic [CNT_W-1:0] FIRST_OUT    = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX      = CNT_W'(FB);

    frame_state_t     state, nxt;
    logic             sclk_d, csn_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [FB-1:0]    shreg;
    logic [DATA_W-1:0] out_sh;
    logic [OUT_W-1:0] out_left;
    logic             load_pend;
    logic             rd_frame;
    logic             sclk_rise, sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign rd_addr   = shreg[ADDR_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!csn_s) nxt = ST_CMD;
            ST_CMD: begin
                if (csn_s)                                  nxt = ST_IDLE;
                else if (sclk_rise && bit_cnt == LAST_CMD_BIT) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (csn_s)                              nxt = ST_IDLE;
                else if (sclk_rise && bit_cnt == LAST_BIT) nxt = ST_FULL;
            end
            ST_FULL: if (csn_s) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // frame datapath: edge history, input shifter, read shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            csn_d     <= 1'b1;
            bit_cnt   <= '0;
            shreg     <= '0;
            out_sh    <= '0;
            out_left  <= '0;
            load_pend <= 1'b0;
            rd_frame  <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            csn_d     <= csn_s;
            load_pend <= (state == ST_CMD) && (nxt == ST_DATA);
            if (state == ST_IDLE) begin
                bit_cnt  <= '0;
                out_left <= '0;
                rd_frame <= 1'b0;
            end else begin
                if ((state == ST_CMD || state == ST_DATA) && sclk_rise && !csn_s) begin
                    shreg   <= {shreg[FB-2:0], sdi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (load_pend) begin
                    out_sh   <= rd_data;
                    out_left <= OUT_W'(DATA_W);
                    rd_frame <= shreg[DATA_W-1];
                end else if (sclk_fall && out_left != '0 && bit_cnt >= FIRST_OUT) begin
                    out_sh   <= {out_sh[DATA_W-2:0], 1'b0};
                    out_left <= out_left - 1'b1;
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            cur_addr <= '0;
            sdo_bit  <= 1'b0;
            sdo_oe   <= 1'b0;
        end else begin
            sdo_oe <= (nxt != ST_IDLE);
            wr_en  <= 1'b0;
            if (state == ST_FULL && csn_s) begin
                wr_en    <= ~shreg[FB-1];
                wr_addr  <= shreg[DATA_W +: ADDR_W];
                wr_data  <= shreg[DATA_W-1:0];
                cur_addr <= shreg[DATA_W +: ADDR_W];
            end
            if (state == ST_IDLE)
                sdo_bit <= 1'b0;
            else if (!load_pend && sclk_fall && out_left != '0 && bit_cnt >= FIRST_OUT)
                sdo_bit <= rd_frame & out_sh[DATA_W-1];
        end
    end

    AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_MAX) else $error("bit count past frame length"); // R1

    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CMD || state == ST_DATA) && csn_s) |=> !wr_en); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_FULL && csn_s) |=> $stable(cur_addr)); // R10

    AST_FULL_IGNORES_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |=> $stable(shreg)); // R5

    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_bit) |-> ($past(sclk_fall) || $past(state == ST_IDLE))); // R6

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [DATA_W-1:0]            rdata,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_flat
);

    localparam int unsigned NUM_REGS = 1 << ADDR_W;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs_flat[i*DATA_W +: DATA_W] <= '0;
                else if (we && waddr == ADDR_W'(i))
                    regs_flat[i*DATA_W +: DATA_W] <= wdata;
            end
        end
    endgenerate

    assign rdata = regs_flat[raddr*DATA_W +: DATA_W];

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat)); // R3

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = BYTE_BITS,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NUM_REGS   = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spi_sclk,
    input  logic                         spi_csn,
    input  logic                         spi_sdi,
    output logic                         spi_sdo,
    output logic                         spi_sdo_oe,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

    logic [2:0]        pins_s;
    logic              sclk_s, csn_s, sdi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en, sdo_bit;

    spi_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in ({spi_sclk, spi_csn, spi_sdi}),
        .pins_out(pins_s)
    );

    assign {sclk_s, csn_s, sdi_s} = pins_s;

    spi_frame_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .csn_s   (csn_s),
        .sdi_s   (sdi_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cur_addr(cur_addr),
        .sdo_bit (sdo_bit),
        .sdo_oe  (spi_sdo_oe)
    );

    spi_reg_bank #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .raddr    (rd_addr),
        .rdata    (rd_data),
        .regs_flat(regs_flat)
    );

    assign spi_sdo = spi_sdo_oe ? sdo_bit : 1'bz;

    AST_SDO_HIZ_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |-> !spi_sdo_oe); // R7

    AST_SDO_DRIVEN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn_s && !$past(csn_s)) |-> spi_sdo_oe); // R7

endmodule

// File: tb/spi_cfg_regs_bench.sv
module spi_cfg_regs_bench;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NREG   = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe;
    logic [ADDR_W-1:0] cur_addr;
    logic [NREG*DATA_W-1:0] regs_flat;

    always #2 clk = ~clk;

    spi_cfg_regs u_spi_cfg_regs (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .cur_addr(cur_addr), .regs_flat(regs_flat)
    );

    typedef struct {
        int         kind;
        int         idx;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t      sb[$];
    int         vectors = 0, fails = 0;
    int         req_cnt = 0, done_cnt = 0;
    logic [7:0] exp_regs [NREG];
    logic [3:0] exp_addr = '0;
    logic [7:0] obs_rd = '0;
    logic       obs_oe_sel = 1'b0;
    bit         finished = 0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input int idx, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic check();
        req_cnt++;
        wait (done_cnt == req_cnt);
    endtask

    task automatic push_bank(input string req);
        for (int i = 0; i < NREG; i++) push(0, i, exp_regs[i], req);
        push(1, 0, {4'b0, exp_addr}, req);
        push(3, 0, 8'h00, "R7");
    endtask

    // drives one frame of nclk serial clocks, then deselects for desel cycles
    task automatic send(input logic [7:0] cmd, input logic [7:0] dat,
                        input int nclk, input int desel, input logic extra);
        logic [15:0] w;
        w = {cmd, dat};
        obs_oe_sel = 1'b0;
        spi_csn = 1'b0;
        tick(4);
        for (int i = 0; i < nclk; i++) begin
            spi_sdi = (i < 16) ? w[15-i] : extra;
            tick(4);
            spi_sclk = 1'b1;
            tick(8);
            spi_sclk = 1'b0;
            tick(7);
            if (i == 10) obs_oe_sel = spi_sdo_oe;
            if (i >= 8 && i < 16) obs_rd[15-i] = spi_sdo;
            tick(1);
        end
        spi_csn = 1'b1;
        spi_sdi = 1'b0;
        if (nclk >= 16) begin
            exp_addr = cmd[3:0];
            if (!cmd[7]) exp_regs[cmd[3:0]] = dat;
        end
        tick(desel);
    endtask

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            wait (req_cnt > done_cnt);
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                unique case (it.kind)
                    0: act = regs_flat[it.idx*DATA_W +: DATA_W];
                    1: act = {4'b0, cur_addr};
                    2: act = obs_rd;
                    3: act = {7'b0, spi_sdo_oe};
                    default: act = {7'b0, obs_oe_sel};
                endcase
                vectors++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
            done_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R8: reset state
        push_bank("R8");
        check();

        // R3 R2 R10: write then check bank
        send(8'h05, 8'hA5, 16, 6, 1'b0);
        push_bank("R3");
        check();

        // R6: read back, oe driven during frame, bank untouched
        send(8'h85, 8'h00, 16, 6, 1'b0);
        push(2, 0, 8'hA5, "R6");
        push(4, 0, 8'h01, "R7");
        push_bank("R6");
        check();

        // R1: address 15, alternating data, reserved bits set on a write
        send(8'h0F, 8'h3C, 16, 6, 1'b0);
        send(8'h73, 8'hC3, 16, 6, 1'b0);
        push_bank("R1");
        check();
        send(8'hFF, 8'h00, 16, 6, 1'b0);
        push(2, 0, 8'h3C, "R1");
        push(1, 0, 8'h0F, "R10");
        check();

        // R4: aborted frames, after 12 and after 5 clocks
        send(8'h02, 8'h77, 12, 6, 1'b0);
        push_bank("R4");
        check();
        send(8'h06, 8'h99, 5, 6, 1'b0);
        push_bank("R4");
        check();

        // R5: extra clocks with ones on data line
        send(8'h09, 8'h5A, 21, 6, 1'b1);
        push_bank("R5");
        check();
        send(8'h89, 8'h00, 20, 6, 1'b1);
        push(2, 0, 8'h5A, "R5");
        check();

        // R9: back-to-back frames with 3-cycle deselect
        send(8'h00, 8'h11, 16, 3, 1'b0);
        send(8'h01, 8'h22, 16, 3, 1'b0);
        send(8'h02, 8'h33, 16, 3, 1'b0);
        send(8'h81, 8'h00, 16, 3, 1'b0);
        push(2, 0, 8'h22, "R9");
        check();
        send(8'h80, 8'h00, 16, 6, 1'b0);
        push(2, 0, 8'h11, "R9");
        push_bank("R9");
        check();

        // R6: unwritten register reads zero
        send(8'h8C, 8'hFF, 16, 6, 1'b0);
        push(2, 0, 8'h00, "R6");
        push(1, 0, 8'h0C, "R10");
        check();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule